// File: doc/BRIEF.md
# Programmable Fast-Trigger Decision Logic

This block turns a vector of discriminator and pulse-shaper signals into a fast-trigger request. Up to eight product terms are evaluated in parallel. Each term can require any input to be high or to be low. The request is the OR of all terms that fire. Each term owns one bit of an 8-bit trigger-type word. On the cycle the request first rises, that word records which terms fired, so later validation stages can tell what caused the trigger.

A separate qualifier term can be switched on to gate every term except one chosen bypass term. A typical use is an acceptance window, such as "fold at least the low threshold and not above the high threshold". The bypass term still triggers on its own.

The masks, the qualifier and the control fields sit in a small register file. It is written through a simple write strobe, address and data port. After reset it holds a working default configuration. Inputs are asynchronous to the clock. They pass through two synchroniser flops and one alignment register before the terms see them.

Top module: `trig_decide`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `trig_req` is 0 and `trig_type` is 0. Reset also restores the default configuration of R9.
- R2: A change on `sig_in` that is then held steady reaches `trig_req` on the fourth rising clock edge after it is applied. It has no effect on `trig_req` at the third edge.
- R3: A term fires when every input set in its require-true mask is 1 and every input set in its require-false mask is 0.
- R4: A term whose require-true and require-false masks are both zero never fires, whatever the inputs are.
- R5: `trig_req` is 1 exactly when at least one term fired on the previous evaluation, one register after the input alignment stage.
- R6: `trig_type` bit i holds whether term i fired, captured on the edge where `trig_req` rises. The value is held while `trig_req` stays high, after it falls, and until the next rise.
- R7: When the qualifier enable bit is 1 and the qualifier term is not satisfied, only the bypass term can fire. When the qualifier is satisfied, all terms act as in R3.
- R8: When the qualifier enable bit is 0, the qualifier masks have no effect on any term.
- R9: Input positions are fixed. Fold discriminators of group A are on bits 0-3, group B on bits 4-6, group C on bits 7-8 and group D on bit 9. Logic inputs 1-10 are on bits 10-19. The default configuration is: term0 = bit 0, term1 = bit 4, term2 = bit 1 AND bit 10, term3 = bit 7, term4 = bit 9. Terms 5-7 are disabled, the qualifier is off and the bypass index is 0.
- R10: Register addresses are as follows:
  - addresses 0-7 hold the require-true masks of terms 0-7;
  - addresses 8-15 hold the require-false masks of terms 0-7;
  - address 16 holds the qualifier require-true mask;
  - address 17 holds the qualifier require-false mask;
  - address 18 is control.
  
  A write lands on the rising edge where `cfg_we` is 1. Writes to addresses 19-31 change nothing.
- R11: In the control register, bit 0 is the qualifier enable and bits 3:1 hold the index of the bypass term.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register address |
| cfg_wdata | input | 20 | Register write data |
| sig_in | input | 20 | Asynchronous discriminator and logic inputs |
| trig_req | output | 1 | Registered fast-trigger request |
| trig_type | output | 8 | Per-term cause word latched at request rise |

## Verification
The properties assume that reset is held for at least two clock edges. This ensures the synchroniser and alignment stages hold zeros before the first checked edge, so the request relation and the type-hold property start from a known, quiet pipeline. The bench holds reset for several cycles before each scenario. It drives `sig_in` and the register port only on falling edges. Every new input pattern is held for at least four rising edges before outputs are sampled, which keeps each stimulus settled through the whole input pipeline. Input patterns return to zero between triggers, so each expected type word comes from a fresh rise of the request.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int DEF_N_IN   = 20;
  localparam int DEF_N_TERM = 8;

  // fixed input positions used by the default configuration
  localparam int POS_A1 = 0;
  localparam int POS_A2 = 1;
  localparam int POS_B1 = 4;
  localparam int POS_C1 = 7;
  localparam int POS_D1 = 9;
  localparam int POS_L1 = 10;

  // control register layout
  localparam int CTRL_QEN_BIT = 0;
  localparam int CTRL_BYP_LSB = 1;
endpackage

// File: rtl/trig_in_sync.sv
module trig_in_sync #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_aligned
);
  logic [W-1:0] meta_q, sync_q, align_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q  <= '0;
      sync_q  <= '0;
      align_q <= '0;
    end else begin
      meta_q  <= d_async;
      sync_q  <= meta_q;
      align_q <= sync_q;
    end
  end

  assign d_aligned = align_q;
endmodule

// File: rtl/trig_term.sv
module trig_term #(
  parameter int W = 20
) (
  input  logic [W-1:0] vec,
  input  logic [W-1:0] need_hi,
  input  logic [W-1:0] need_lo,
  output logic         hit
);
  logic enabled, hi_ok, lo_ok;

  always_comb begin
    enabled = |(need_hi | need_lo);
    hi_ok   = ((vec & need_hi) == need_hi);
    lo_ok   = ((vec & need_lo) == '0);
    hit     = enabled && hi_ok && lo_ok;
  end
endmodule

// File: rtl/trig_cfg_regs.sv
module trig_cfg_regs
  import trig_pkg::*;
#(
  parameter int N_IN   = DEF_N_IN,
  parameter int N_TERM = DEF_N_TERM,
  localparam int ADDRW = $clog2(2 * N_TERM + 3),
  localparam int IDXW  = $clog2(N_TERM)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [ADDRW-1:0]              wr_addr,
  input  logic [N_IN-1:0]               wr_data,
  output logic [N_TERM-1:0][N_IN-1:0]   hi_masks,
  output logic [N_TERM-1:0][N_IN-1:0]   lo_masks,
  output logic [N_IN-1:0]               qual_hi,
  output logic [N_IN-1:0]               qual_lo,
  output logic                          qual_en,
  output logic [IDXW-1:0]               byp_idx
);
  localparam int A_QHI  = 2 * N_TERM;
  localparam int A_QLO  = 2 * N_TERM + 1;
  localparam int A_CTRL = 2 * N_TERM + 2;

  typedef logic [N_TERM-1:0][N_IN-1:0] mask_arr_t;

  function automatic mask_arr_t build_defaults();
    mask_arr_t m;
    m = '0;
    m[0][POS_A1] = 1'b1;
    m[1][POS_B1] = 1'b1;
    m[2][POS_A2] = 1'b1;
    m[2][POS_L1] = 1'b1;
    m[3][POS_C1] = 1'b1;
    m[4][POS_D1] = 1'b1;
    return m;
  endfunction

  localparam mask_arr_t DEF_HI = build_defaults();

  mask_arr_t         hi_q, lo_q;
  logic [N_IN-1:0]   qhi_q, qlo_q;
  logic              qen_q;
  logic [IDXW-1:0]   byp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q  <= DEF_HI;
      lo_q  <= '0;
      qhi_q <= '0;
      qlo_q <= '0;
      qen_q <= 1'b0;
      byp_q <= '0;
    end else if (wr_en) begin
      for (int t = 0; t < N_TERM; t++) begin
        if (wr_addr == ADDRW'(t))          hi_q[t] <= wr_data;
        if (wr_addr == ADDRW'(N_TERM + t)) lo_q[t] <= wr_data;
      end
      if (wr_addr == ADDRW'(A_QHI)) qhi_q <= wr_data;
      if (wr_addr == ADDRW'(A_QLO)) qlo_q <= wr_data;
      if (wr_addr == ADDRW'(A_CTRL)) begin
        qen_q <= wr_data[CTRL_QEN_BIT];
        byp_q <= wr_data[CTRL_BYP_LSB +: IDXW];
      end
    end
  end

  assign hi_masks = hi_q;
  assign lo_masks = lo_q;
  assign qual_hi  = qhi_q;
  assign qual_lo  = qlo_q;
  assign qual_en  = qen_q;
  assign byp_idx  = byp_q;
endmodule

// File: rtl/trig_decide.sv
module trig_decide
  import trig_pkg::*;
#(
  parameter int N_IN   = DEF_N_IN,
  parameter int N_TERM = DEF_N_TERM,
  localparam int ADDRW = $clog2(2 * N_TERM + 3),
  localparam int IDXW  = $clog2(N_TERM)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDRW-1:0]  cfg_addr,
  input  logic [N_IN-1:0]   cfg_wdata,
  input  logic [N_IN-1:0]   sig_in,
  output logic              trig_req,
  output logic [N_TERM-1:0] trig_type
);
  logic [N_IN-1:0]             sig_al;
  logic [N_TERM-1:0][N_IN-1:0] hi_masks, lo_masks;
  logic [N_IN-1:0]             qual_hi, qual_lo;
  logic                        qual_en;
  logic [IDXW-1:0]             byp_idx;
  logic [N_TERM-1:0]           term_raw, term_vec;
  logic                        qual_hit, qual_ok;
  logic                        req_q;
  logic [N_TERM-1:0]           type_q;

  trig_in_sync #(.W(N_IN)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .d_async   (sig_in),
    .d_aligned (sig_al)
  );

  trig_cfg_regs #(.N_IN(N_IN), .N_TERM(N_TERM)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (cfg_we),
    .wr_addr  (cfg_addr),
    .wr_data  (cfg_wdata),
    .hi_masks (hi_masks),
    .lo_masks (lo_masks),
    .qual_hi  (qual_hi),
    .qual_lo  (qual_lo),
    .qual_en  (qual_en),
    .byp_idx  (byp_idx)
  );

  trig_term #(.W(N_IN)) u_qual (
    .vec     (sig_al),
    .need_hi (qual_hi),
    .need_lo (qual_lo),
    .hit     (qual_hit)
  );

  assign qual_ok = !qual_en || qual_hit;

  for (genvar i = 0; i < N_TERM; i++) begin : g_term
    trig_term #(.W(N_IN)) u_term (
      .vec     (sig_al),
      .need_hi (hi_masks[i]),
      .need_lo (lo_masks[i]),
      .hit     (term_raw[i])
    );
    assign term_vec[i] = term_raw[i] && (qual_ok || (byp_idx == IDXW'(i)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      type_q <= '0;
    end else begin
      req_q <= |term_vec;
      if ((|term_vec) && !req_q) type_q <= term_vec;
    end
  end

  assign trig_req  = req_q;
  assign trig_type = type_q;
endmodule

// File: rtl/trig_decide_chk.sv
module trig_decide_chk #(
  parameter int N_IN   = 20,
  parameter int N_TERM = 8,
  localparam int IDXW  = $clog2(N_TERM)
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        trig_req,
  input logic [N_TERM-1:0]           trig_type,
  input logic [N_TERM-1:0]           term_vec,
  input logic [N_TERM-1:0][N_IN-1:0] hi_masks,
  input logic [N_TERM-1:0][N_IN-1:0] lo_masks,
  input logic                        qual_en,
  input logic                        qual_hit,
  input logic [IDXW-1:0]             byp_idx
);
  logic [N_TERM-1:0] byp_bit;
  assign byp_bit = N_TERM'(1) << byp_idx;

  // R5: request follows the OR of the gated terms one edge later
  p_req_follows_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (trig_req == $past(|term_vec)));

  // R6: type word only moves on a request rise
  p_type_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !$stable(trig_type) |-> $rose(trig_req));

  // R6: a rise always records at least one cause
  p_type_nonzero_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(trig_req) |-> (trig_type != '0));

  // R7: failed qualifier leaves only the bypass term
  p_qual_block_r7: assert property (@(posedge clk) disable iff (rst)
    (qual_en && !qual_hit) |-> ((term_vec & ~byp_bit) == '0));

  for (genvar i = 0; i < N_TERM; i++) begin : g_dis
    // R4: empty masks keep a term silent
    p_empty_term_r4: assert property (@(posedge clk) disable iff (rst)
      ((hi_masks[i] == '0) && (lo_masks[i] == '0)) |-> !term_vec[i]);
  end
endmodule

bind trig_decide trig_decide_chk #(.N_IN(N_IN), .N_TERM(N_TERM)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .trig_req  (trig_req),
  .trig_type (trig_type),
  .term_vec  (term_vec),
  .hi_masks  (hi_masks),
  .lo_masks  (lo_masks),
  .qual_en   (qual_en),
  .qual_hit  (qual_hit),
  .byp_idx   (byp_idx)
);

// File: tb/trig_decide_test.sv
module trig_decide_test;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 20;
  localparam int NT = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [4:0]    cfg_addr = '0;
  logic [NI-1:0] cfg_wdata = '0;
  logic [NI-1:0] sig_in = '0;
  logic          trig_req;
  logic [NT-1:0] trig_type;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trig_decide uut (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .sig_in    (sig_in),
    .trig_req  (trig_req),
    .trig_type (trig_type)
  );

  function automatic logic [NI-1:0] bits(input int a, input int b = -1, input int c = -1);
    logic [NI-1:0] v = '0;
    v[a] = 1'b1;
    if (b >= 0) v[b] = 1'b1;
    if (c >= 0) v[c] = 1'b1;
    return v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; sig_in = '0; cfg_we = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input int addr, input logic [NI-1:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 5'(addr); cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // drive at a falling edge, wait four rising edges, sample at the next falling edge
  task automatic apply(input logic [NI-1:0] v);
    @(negedge clk);
    sig_in = v;
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_defaults();
    for (int t = 0; t < 5; t++) wr(t, '0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 req in reset", trig_req, 0);
    chk("R1 type in reset", trig_type, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 req after reset", trig_req, 0);
    chk("R1 type after reset", trig_type, 0);
  endtask

  task automatic t_defaults();
    do_reset();
    apply(bits(0));      chk("R9 A1 -> term0", trig_type, 8'h01);
    chk("R9 A1 req", trig_req, 1);
    apply('0);
    apply(bits(1));      chk("R9 A2 alone no req", trig_req, 0);
    apply(bits(1, 10));  chk("R9 A2&L1 -> term2", trig_type, 8'h04);
    apply('0);
    apply(bits(4));      chk("R9 B1 -> term1", trig_type, 8'h02);
    apply('0);
    apply(bits(7));      chk("R9 C1 -> term3", trig_type, 8'h08);
    apply('0);
    apply(bits(9));      chk("R9 D1 -> term4", trig_type, 8'h10);
    apply('0);
    apply(bits(19, 2));  chk("R9 unused inputs no req", trig_req, 0);
    apply('0);
  endtask

  task automatic t_latency();
    do_reset();
    @(negedge clk);
    sig_in = bits(0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R2 not yet at edge 3", trig_req, 0);
    @(negedge clk);
    chk("R2 request at edge 4", trig_req, 1);
    apply('0);
  endtask

  task automatic t_product();
    do_reset();
    clear_defaults();
    wr(5, bits(2, 11));
    wr(8 + 5, bits(12));
    apply(bits(2, 11));     chk("R3 true bits met", trig_type, 8'h20);
    chk("R3 req", trig_req, 1);
    apply(bits(2, 11, 12)); chk("R3 false bit set blocks", trig_req, 0);
    apply(bits(2));         chk("R3 missing true bit", trig_req, 0);
    apply('0);
  endtask

  task automatic t_disabled();
    do_reset();
    clear_defaults();
    apply('1); chk("R4 all ones no req", trig_req, 0);
    apply('0); chk("R4 all zeros no req", trig_req, 0);
  endtask

  task automatic t_or_hold();
    do_reset();
    wr(1, bits(1));
    apply(bits(0));     chk("R5 one term fires", trig_req, 1);
    chk("R6 cause term0", trig_type, 8'h01);
    apply(bits(0, 1));  chk("R6 held while high", trig_type, 8'h01);
    chk("R5 still requesting", trig_req, 1);
    apply('0);          chk("R5 no term no req", trig_req, 0);
    chk("R6 held after fall", trig_type, 8'h01);
    apply(bits(0, 1));  chk("R6 two causes", trig_type, 8'h03);
    apply('0);
  endtask

  task automatic t_qualifier();
    do_reset();
    wr(1, bits(1));
    wr(16, bits(3));
    wr(17, bits(4));
    wr(18, 20'h3);      // enable, bypass = term1
    apply(bits(0));        chk("R7 qualifier fails blocks", trig_req, 0);
    apply(bits(0, 3));     chk("R7 inside window", trig_type, 8'h01);
    apply('0);
    apply(bits(0, 3, 4));  chk("R7 above window", trig_req, 0);
    apply(bits(1));        chk("R7 bypass alone", trig_type, 8'h02);
    apply('0);
    apply(bits(0, 1));     chk("R7 only bypass recorded", trig_type, 8'h02);
    apply('0);
    wr(18, 20'h2);      // disable qualifier, bypass unchanged
    apply(bits(0));        chk("R8 qualifier off", trig_type, 8'h01);
    apply('0);
    apply(bits(0, 3, 4));  chk("R8 qualifier masks ignored", trig_type, 8'h01);
    apply('0);
  endtask

  task automatic t_map();
    do_reset();
    for (int a = 19; a < 32; a++) wr(a, '1);
    apply('0);       chk("R10 unmapped writes no req", trig_req, 0);
    apply(bits(0));  chk("R10 defaults intact", trig_type, 8'h01);
    apply('0);
    wr(5, bits(5));
    wr(16, bits(6));
    wr(18, 20'hB);   // enable, bypass = term5
    apply(bits(5));  chk("R11 bypass index 5", trig_type, 8'h20);
    apply('0);
    apply(bits(4));  chk("R11 term1 gated", trig_req, 0);
    apply('0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    t_reset();
    t_defaults();
    t_latency();
    t_product();
    t_disabled();
    t_or_hold();
    t_qualifier();
    t_map();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule